// File: doc/BRIEF.md
# NOR Flash Command Sequence Engine

This block stands in for the command interpreter and the embedded write machine of a parallel NOR flash. A host issues bus write cycles on a strobe (`we_n`), an address and a 16-bit data word. Unlock patterns made of several cycles are decoded into one of three operations: program one word, erase one sector, or erase the whole chip. The operation then runs for a fixed number of clock cycles and is applied to a small on-chip array of 39 sectors. Per-sector lock inputs are honoured throughout.

While an operation runs, `busy` is high and every bus write is discarded. An erase or program aimed at a locked sector, or at an address outside the array, ends early and raises `fail`. `fail` stays set until the host writes the exit code. Reads use a separate combinational port.

Top module: `nor_cmd_engine`

## Requirements
- R1: While `rst_n` is low, `busy` and `fail` are low from the next clock and the decoder is idle. An operation that is running is abandoned and changes no array word. Once `rst_n` is high again, new sequences are accepted.
- R2: A bus write cycle is one low pulse on `we_n`. The address is taken at the clock where the falling edge of `we_n` is seen. The data is taken at the clock where the rising edge is seen, and that rising edge completes the cycle.
- R3: Only `wdata[7:0]` is compared with command codes. `wdata[15:8]` has no effect on any command cycle.
- R4: Programming takes four writes: 555h/AAh, 2AAh/55h, 555h/A0h, then target address and data. The stored word becomes old AND data. `busy` is high for exactly T_PROG cycles, starting with the cycle after the last write.
- R5: Sector erase takes six writes: 555h/AAh, 2AAh/55h, 555h/80h, 555h/AAh, 2AAh/55h, then any address in the sector with code 30h. Every word of that sector becomes FFFFh. `busy` is high for T_SERASE cycles.
- R6: Chip erase uses the same first five writes, then 555h/10h. Every word in each unlocked sector becomes FFFFh and locked sectors are not changed. `busy` is high for T_CERASE cycles and `fail` stays low.
- R7: A sector erase or program aimed at a locked sector, or at an address outside the array, holds `busy` for T_ABORT cycles. It changes no data and sets `fail` when `busy` falls.
- R8: Every bus write made while `busy` is high is ignored. It neither advances a sequence nor changes data.
- R9: While `fail` is set, a write with low byte F0h clears it. Every other write is ignored.
- R10: A write that does not match the next expected step sends the decoder back to idle, and that write is discarded.
- R11: The word index is {sector, offset}, with the offset in the low log2(SECT_WORDS) bits and the sector (0 to 38) in the bits above it. Every higher address bit must be zero.
- R12: `rd_data` shows the word at `rd_addr` in the same cycle, or FFFFh when `rd_addr` lies outside the array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; halts any operation |
| we_n | input | 1 | Active-low write strobe |
| addr | input | AW | Write address |
| wdata | input | 16 | Write data |
| sect_lock | input | NSECT | One lock bit per sector |
| rd_addr | input | AW | Read address |
| rd_data | output | 16 | Read data |
| busy | output | 1 | Operation in progress |
| fail | output | 1 | Last operation was refused |

## Verification
A decoder left in the wrong state shows at the ports on the next completed write: a program or erase either lands when it should not or fails to land, and a read of the array exposes it. A wrong countdown shows as a `busy` pulse whose length is not T_PROG, T_SERASE, T_CERASE or T_ABORT, counted from the cycle after the write. A bad lock or range decision shows as a `fail` that is raised when it should stay low, or the reverse, the moment `busy` falls, together with array words that were erased when they should have been kept, or kept when they should have been erased.

// File: rtl/nor_cmd_engine.sv
module nor_cmd_engine #(
  parameter int AW         = 12,
  parameter int SECT_WORDS = 4,
  parameter int NSECT      = 39,
  parameter int CNT_W      = 16,
  parameter int T_PROG     = 6,
  parameter int T_SERASE   = 12,
  parameter int T_CERASE   = 24,
  parameter int T_ABORT    = 3,
  parameter logic [AW-1:0] UNLK_A = AW'('h555),
  parameter logic [AW-1:0] UNLK_B = AW'('h2AA)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_n,
  input  logic [AW-1:0]    addr,
  input  logic [15:0]      wdata,
  input  logic [NSECT-1:0] sect_lock,
  input  logic [AW-1:0]    rd_addr,
  output logic [15:0]      rd_data,
  output logic             busy,
  output logic             fail
);
  localparam int OW    = $clog2(SECT_WORDS);
  localparam int SW    = $clog2(NSECT);
  localparam int IW    = OW + SW;
  localparam int DEPTH = NSECT * SECT_WORDS;

  localparam logic [2:0] S_IDLE = 3'd0, S_U1 = 3'd1, S_U2 = 3'd2, S_PRG = 3'd3,
                         S_E3 = 3'd4, S_E4 = 3'd5, S_E5 = 3'd6;
  localparam logic [1:0] OP_PRG = 2'd0, OP_SER = 2'd1, OP_CER = 2'd2, OP_ABT = 2'd3;

  logic [15:0]      mem [DEPTH];
  logic             we_q;
  logic [AW-1:0]    a_lat;
  logic [2:0]       state;
  logic [1:0]       op;
  logic [CNT_W-1:0] cnt;
  logic [IW-1:0]    t_idx;
  logic [15:0]      t_dat;

  function automatic logic in_arr(input logic [AW-1:0] a);
    return (a[AW-1:IW] == '0) && (a[IW-1:OW] < SW'(NSECT));
  endfunction

  wire          fall   = we_q & ~we_n;
  wire          rise   = ~we_q & we_n;
  wire [7:0]    cmd    = wdata[7:0];
  wire          a_ok   = in_arr(a_lat);
  wire [SW-1:0] a_sec  = a_lat[IW-1:OW];
  wire          a_lock = !a_ok || sect_lock[a_sec];
  wire          hit_a  = (a_lat == UNLK_A);
  wire          hit_b  = (a_lat == UNLK_B);
  wire          done   = busy && (cnt == '0);

  assign rd_data = in_arr(rd_addr) ? mem[rd_addr[IW-1:0]] : 16'hFFFF;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      we_q  <= 1'b1;
      a_lat <= '0;
      state <= S_IDLE;
      busy  <= 1'b0;
      fail  <= 1'b0;
      cnt   <= '0;
      op    <= OP_PRG;
      t_idx <= '0;
      t_dat <= '0;
    end else begin
      we_q <= we_n;
      if (fall) a_lat <= addr;
      if (busy) begin
        if (cnt == '0) begin
          busy <= 1'b0;
          if (op == OP_ABT) fail <= 1'b1;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end else if (rise) begin
        state <= S_IDLE;
        if (fail) begin
          if (cmd == 8'hF0) fail <= 1'b0;
        end else begin
          case (state)
            S_IDLE: if (hit_a && cmd == 8'hAA) state <= S_U1;
            S_U1:   if (hit_b && cmd == 8'h55) state <= S_U2;
            S_U2: begin
              if (hit_a && cmd == 8'hA0) state <= S_PRG;
              else if (hit_a && cmd == 8'h80) state <= S_E3;
            end
            S_PRG: begin
              busy  <= 1'b1;
              t_idx <= a_lat[IW-1:0];
              t_dat <= wdata;
              if (a_lock) begin op <= OP_ABT; cnt <= CNT_W'(T_ABORT - 1); end
              else        begin op <= OP_PRG; cnt <= CNT_W'(T_PROG - 1); end
            end
            S_E3: if (hit_a && cmd == 8'hAA) state <= S_E4;
            S_E4: if (hit_b && cmd == 8'h55) state <= S_E5;
            S_E5: begin
              if (hit_a && cmd == 8'h10) begin
                busy <= 1'b1;
                op   <= OP_CER;
                cnt  <= CNT_W'(T_CERASE - 1);
              end else if (cmd == 8'h30) begin
                busy  <= 1'b1;
                t_idx <= a_lat[IW-1:0];
                if (a_lock) begin op <= OP_ABT; cnt <= CNT_W'(T_ABORT - 1); end
                else        begin op <= OP_SER; cnt <= CNT_W'(T_SERASE - 1); end
              end
            end
            default: state <= S_IDLE;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n && done) begin
      case (op)
        OP_PRG: mem[t_idx] <= mem[t_idx] & t_dat;
        OP_SER:
          for (int w = 0; w < SECT_WORDS; w++)
            mem[{t_idx[IW-1:OW], OW'(w)}] <= 16'hFFFF;
        OP_CER:
          for (int s = 0; s < NSECT; s++)
            if (!sect_lock[s])
              for (int w = 0; w < SECT_WORDS; w++)
                mem[{SW'(s), OW'(w)}] <= 16'hFFFF;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/nor_cmd_engine_chk.sv
module nor_cmd_engine_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             we_n,
  input logic             busy,
  input logic             fail,
  input logic [2:0]       state,
  input logic [CNT_W-1:0] cnt
);
  a_r1_reset_quiet: assert property (@(posedge clk) !rst_n |=> (!busy && !fail));

  a_r8_idle_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> state == 3'd0);

  a_r4_countdown: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && $past(cnt) != '0) |-> cnt == $past(cnt) - 1'b1);

  a_r2_start_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(we_n) && !$past(we_n, 2)));

  a_r7_fail_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fail) |-> ($past(busy) && !busy));

  a_r9_fail_clear_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fail) |-> ($past(we_n) && !$past(we_n, 2)));
endmodule

bind nor_cmd_engine nor_cmd_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .we_n(we_n), .busy(busy), .fail(fail),
  .state(state), .cnt(cnt)
);

// File: tb/nor_cmd_engine_test.sv
`timescale 1ns/1ps
module nor_cmd_engine_test;
  localparam int NS = 39, SWD = 4, NW = NS * SWD;
  localparam int TP = 6, TS = 12, TC = 24, TA = 3;

  logic clk = 0, rst_n = 0, we_n = 1;
  logic [11:0] addr = 0, rd_addr = 0;
  logic [15:0] wdata = 0, rd_data;
  logic [NS-1:0] sect_lock = '0;
  logic busy, fail;
  int checks = 0, errors = 0;
  logic [15:0] model [NW];

  nor_cmd_engine uut (.clk(clk), .rst_n(rst_n), .we_n(we_n), .addr(addr), .wdata(wdata),
    .sect_lock(sect_lock), .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy), .fail(fail));

  always #5 clk = ~clk;

  task automatic chk(input string r, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [15:0] d);
    @(negedge clk); addr = a; wdata = ~d; we_n = 0;
    @(negedge clk); addr = ~a; wdata = d; we_n = 1;
    @(negedge clk);
  endtask

  task automatic unlock(input logic [7:0] hi);
    wr(12'h555, {hi, 8'hAA}); wr(12'h2AA, {hi, 8'h55});
  endtask

  task automatic prog(input logic [11:0] a, input logic [15:0] d, input logic [7:0] hi);
    unlock(hi); wr(12'h555, {hi, 8'hA0}); wr(a, d);
  endtask

  task automatic erase6(input logic [11:0] a, input logic [7:0] code, input logic [7:0] hi);
    unlock(hi); wr(12'h555, {hi, 8'h80}); unlock(hi); wr(a, {hi, code});
  endtask

  task automatic blen(output int n);
    n = 0;
    while (busy && n < 1000) begin n++; @(negedge clk); end
  endtask

  task automatic verify(input string r);
    for (int i = 0; i < NW; i++) begin
      rd_addr = 12'(i); #1;
      chk(r, rd_data, model[i]);
    end
  endtask

  function automatic logic [15:0] pat(input int i, input int k);
    return 16'(i * 40503 + k * 7919) ^ 16'hA5C3;
  endfunction

  initial begin
    #1_999_000;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    chk("R1 busy in reset", busy, 0);
    chk("R1 fail in reset", fail, 0);
    rst_n = 1;
    @(negedge clk);

    erase6(12'h555, 8'h10, 8'h3C); blen(n);
    chk("R6 chip erase busy len", n, TC);
    chk("R6 no fail", fail, 0);
    for (int i = 0; i < NW; i++) model[i] = 16'hFFFF;
    verify("R6 erased");

    for (int k = 1; k <= 2; k++)
      for (int i = 0; i < NW; i++) begin
        prog(12'(i), pat(i, k), 8'(i + k)); blen(n);
        chk("R4 program busy len", n, TP);
        model[i] &= pat(i, k);
      end
    verify("R4 AND program sweep");

    erase6(12'h000, 8'h30, 8'h00); @(negedge clk);
    prog(12'h005, 16'h0000, 8'h00); blen(n);
    for (int w = 0; w < SWD; w++) model[w] = 16'hFFFF;
    verify("R8 writes during busy ignored");

    prog(12'h010, 16'h1234, 8'h00); blen(n);
    model[16] &= 16'h1234;
    wr(12'h555, 16'h00AA); wr(12'h2AA, 16'h0056); wr(12'h2AA, 16'h0055);
    wr(12'h555, 16'h00A0); wr(12'h011, 16'h0000);
    chk("R10 mismatch no busy", busy, 0);
    verify("R10 mismatch discarded");

    sect_lock = '0;
    for (int s = 0; s < NS; s++) sect_lock[s] = (s % 3 == 1);
    for (int s = 0; s < NS; s++) begin
      erase6(12'(s * SWD + 1), 8'h30, 8'(s)); blen(n);
      if (s % 3 == 1) begin
        chk("R7 locked abort len", n, TA);
        chk("R7 fail raised", fail, 1);
        if (s == 1) begin
          prog(12'h000, 16'h0000, 8'h00);
          chk("R9 no busy while fail", busy, 0);
          wr(12'h555, 16'h00AA);
          chk("R9 fail held", fail, 1);
        end
        wr(12'h000, 16'h77F0);
        chk("R9 F0 clears fail", fail, 0);
      end else begin
        chk("R5 sector erase len", n, TS);
        chk("R5 no fail", fail, 0);
        for (int w = 0; w < SWD; w++) model[s * SWD + w] = 16'hFFFF;
      end
    end
    verify("R5 R7 sector erase sweep");

    sect_lock = '0;
    for (int i = 0; i < NW; i++) begin
      prog(12'(i), pat(i, 3), 8'h5A); blen(n);
      model[i] &= pat(i, 3);
    end
    for (int s = 0; s < NS; s++) sect_lock[s] = (s % 4 == 2);
    erase6(12'h555, 8'h10, 8'hE1); blen(n);
    chk("R6 lock chip erase len", n, TC);
    chk("R6 lock chip no fail", fail, 0);
    for (int i = 0; i < NW; i++) if ((i / SWD) % 4 != 2) model[i] = 16'hFFFF;
    verify("R6 locked sectors kept");

    prog(12'(40 * SWD), 16'h0000, 8'h00); blen(n);
    chk("R11 out of range abort len", n, TA);
    chk("R11 out of range fail", fail, 1);
    wr(12'h000, 16'h00F0);
    prog(12'h100, 16'h0000, 8'h00); blen(n);
    chk("R11 high bits abort len", n, TA);
    wr(12'h000, 16'h00F0);
    rd_addr = 12'h9C; #1; chk("R12 read beyond array", rd_data, 16'hFFFF);
    rd_addr = 12'h800; #1; chk("R12 read high bits", rd_data, 16'hFFFF);
    verify("R12 R3 array intact");

    sect_lock = '0;
    prog(12'h008, 16'h0F0F, 8'h00); blen(n);
    model[8] &= 16'h0F0F;
    erase6(12'h009, 8'h30, 8'h00);
    repeat (3) @(negedge clk);
    rst_n = 0; @(negedge clk);
    chk("R1 busy cleared by reset", busy, 0);
    rst_n = 1; @(negedge clk);
    verify("R1 interrupted erase no change");
    prog(12'h008, 16'h00FF, 8'h00); blen(n);
    chk("R1 accepts after reset", n, TP);
    model[8] &= 16'h00FF;
    rd_addr = 12'h008; #1; chk("R2 R4 programmed after reset", rd_data, model[8]);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule